// File: doc/BRIEF.md
# Instruction Fetch Address Unit

This block holds the program counter of a 32-bit load/store processor and decides, every clock cycle, which instruction address comes next. Without any control request the counter moves forward by one word (four bytes). The decoder can instead ask for one of three other kinds of redirect:

- an absolute jump, whose target index is taken from the instruction word;
- a jump through a register, using the first register read value;
- a conditional branch, whose target is relative to the address of the following instruction.

The branch condition is one of four compares. The two lowest opcode bits of the instruction pick which compare is used.

The unit feeds the instruction memory address and also offers the sequential address. The surrounding core can use that sequential address as a link value. Writing the link value into a register and reading instruction memory are done outside the block.

Top module: `fetch_addr_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` is loaded with 0 (synchronous, active high).
- R2: `pc_plus4` always equals `pc_q + 4`, modulo 2^32.
- R3: With no control input asserted, `pc_q` takes the value `pc_q + 4` at each rising edge.
- R4: When `jump_en` or `link_jump_en` is high and `reg_jump_en` is low, the next `pc_q` is built as follows. Bits [31:28] come from `pc_plus4[31:28]`. Bits [27:2] come from `instr[25:0]`. Bits [1:0] are zero.
- R5: When `reg_jump_en` is high, the next `pc_q` is `rs_val`. This holds whatever the other control inputs are.
- R6: With `branch_en` high, no jump requested and `instr[27:26]` = 00, the branch is taken when `rs_val == rt_val`.
- R7: With `branch_en` high, no jump requested and `instr[27:26]` = 01, the branch is taken when `rs_val != rt_val`.
- R8: With `branch_en` high, no jump requested and `instr[27:26]` = 10, the branch is taken when `rs_val`, read as two's complement, is zero or below.
- R9: With `branch_en` high, no jump requested and `instr[27:26]` = 11, the branch is taken when `rs_val`, read as two's complement, is above zero.
- R10: A taken branch loads `pc_plus4` plus the offset. The offset is `instr[15:0]` sign-extended to 32 bits and shifted left by two. A branch that is not taken, or a true condition while `branch_en` is low, loads `pc_plus4`.
- R11: An absolute jump (R4) has priority over a taken branch.
- R12: A negative 16-bit offset moves the PC backwards, because the sign bit fills the upper address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | First register read value |
| rt_val | input | 32 | Second register read value |
| branch_en | input | 1 | Conditional branch requested |
| jump_en | input | 1 | Absolute jump requested |
| link_jump_en | input | 1 | Absolute jump with link requested |
| reg_jump_en | input | 1 | Jump to the address in `rs_val` |
| pc_q | output | 32 | Current instruction address |
| pc_plus4 | output | 32 | Address of the next sequential instruction |

## Verification
The bench targets the signed compares in three ways. It uses `rs_val` = 0 for both zero-based kinds, so a design that mixes up strict and non-strict compares branches wrongly in one of them. It uses `rs_val` = 0x80000000 for "above zero", so an unsigned compare would take that branch. It uses `rs_val` = 0xFFFFFFF0 for "zero or below", so an unsigned compare would skip it.

A backward branch shows whether the offset is sign-extended, since a zero-extended offset would jump far forward. An absolute jump made from an address with non-zero top bits shows whether the upper four bits are kept. Cases with several controls set at once test priority: the register jump must win over the others, and an absolute jump must win over a taken branch.

// File: rtl/fau_pkg.sv
package fau_pkg;

    localparam int ADDR_W   = 32;
    localparam int IMM_W    = 16;
    localparam int IDX_W    = 26;
    localparam int KIND_LSB = 26;
    localparam int WORD_SH  = 2;
    localparam int STEP     = 4;
    localparam int REGION_W = ADDR_W - IDX_W - WORD_SH;
    localparam int SEXT_W   = ADDR_W - IMM_W - WORD_SH;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_NE  = 2'b01,
        CMP_LEZ = 2'b10,
        CMP_GTZ = 2'b11
    } cmp_kind_e;

    typedef enum logic [1:0] {
        SRC_SEQ,
        SRC_BR,
        SRC_ABS,
        SRC_REG
    } next_src_e;

    typedef struct packed {
        logic reg_jump;
        logic abs_jump;
        logic link_jump;
        logic branch;
    } flow_ctl_t;

    typedef struct packed {
        addr_t seq;
        addr_t br;
        addr_t abs;
        addr_t reg_t;
    } cand_t;

    function automatic addr_t branch_target(addr_t seq, logic [IMM_W-1:0] off);
        return seq + {{SEXT_W{off[IMM_W-1]}}, off, {WORD_SH{1'b0}}};
    endfunction

    function automatic addr_t jump_target(addr_t seq, logic [IDX_W-1:0] idx);
        return {seq[ADDR_W-1 -: REGION_W], idx, {WORD_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/fau_incr.sv
module fau_incr
    import fau_pkg::*;
(
    input  addr_t pc,
    output addr_t seq
);
    assign seq = pc + addr_t'(STEP);
endmodule

// File: rtl/fau_cond.sv
module fau_cond
    import fau_pkg::*;
(
    input  cmp_kind_e kind,
    input  addr_t     a,
    input  addr_t     b,
    output logic      hit
);
    logic a_zero;
    logic a_neg;

    assign a_zero = (a == '0);
    assign a_neg  = a[ADDR_W-1];

    always_comb begin
        unique case (kind)
            CMP_EQ:  hit = (a == b);
            CMP_NE:  hit = (a != b);
            CMP_LEZ: hit = a_neg | a_zero;
            CMP_GTZ: hit = ~a_neg & ~a_zero;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fau_sel.sv
module fau_sel
    import fau_pkg::*;
(
    input  flow_ctl_t ctl,
    input  logic      cond_hit,
    input  cand_t     cand,
    output next_src_e src,
    output addr_t     next_pc
);
    always_comb begin
        if (ctl.reg_jump)
            src = SRC_REG;
        else if (ctl.abs_jump | ctl.link_jump)
            src = SRC_ABS;
        else if (ctl.branch & cond_hit)
            src = SRC_BR;
        else
            src = SRC_SEQ;
    end

    always_comb begin
        unique case (src)
            SRC_REG: next_pc = cand.reg_t;
            SRC_ABS: next_pc = cand.abs;
            SRC_BR:  next_pc = cand.br;
            default: next_pc = cand.seq;
        endcase
    end
endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
    import fau_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    input  logic        branch_en,
    input  logic        jump_en,
    input  logic        link_jump_en,
    input  logic        reg_jump_en,
    output logic [31:0] pc_q,
    output logic [31:0] pc_plus4
);
    flow_ctl_t ctl;
    cand_t     cand;
    cmp_kind_e kind;
    logic      cond_hit;
    next_src_e src;
    addr_t     next_pc;

    assign ctl  = '{reg_jump: reg_jump_en, abs_jump: jump_en,
                    link_jump: link_jump_en, branch: branch_en};
    assign kind = cmp_kind_e'(instr[KIND_LSB +: 2]);

    fau_incr u_incr (
        .pc  (pc_q),
        .seq (pc_plus4)
    );

    fau_cond u_cond (
        .kind (kind),
        .a    (rs_val),
        .b    (rt_val),
        .hit  (cond_hit)
    );

    assign cand.seq   = pc_plus4;
    assign cand.br    = branch_target(pc_plus4, instr[IMM_W-1:0]);
    assign cand.abs   = jump_target(pc_plus4, instr[IDX_W-1:0]);
    assign cand.reg_t = rs_val;

    fau_sel u_sel (
        .ctl      (ctl),
        .cond_hit (cond_hit),
        .cand     (cand),
        .src      (src),
        .next_pc  (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= next_pc;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc_q == '0);

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl == '0) |=> pc_q == $past(pc_plus4));

    // R5
    reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        reg_jump_en |=> pc_q == $past(rs_val));

    // R4
    abs_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_jump_en && (jump_en || link_jump_en)) |=>
            (pc_q[WORD_SH-1:0] == '0) &&
            (pc_q[ADDR_W-1 -: REGION_W] == $past(pc_plus4[ADDR_W-1 -: REGION_W])) &&
            (pc_q[WORD_SH +: IDX_W] == $past(instr[IDX_W-1:0])));

    // R10
    not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_en && !cond_hit && !reg_jump_en && !jump_en && !link_jump_en) |=>
            pc_q == $past(pc_plus4));

    // R2
    word_align_step_chk: assert property (@(posedge clk) disable iff (rst)
        pc_plus4[WORD_SH-1:0] == pc_q[WORD_SH-1:0]);
endmodule

// File: tb/fetch_addr_unit_bench.sv
module fetch_addr_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        branch_en = 1'b0;
    logic        jump_en = 1'b0;
    logic        link_jump_en = 1'b0;
    logic        reg_jump_en = 1'b0;
    logic [31:0] pc_q;
    logic [31:0] pc_plus4;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model_pc = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    fetch_addr_unit u_fetch_addr_unit (
        .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .branch_en(branch_en), .jump_en(jump_en), .link_jump_en(link_jump_en),
        .reg_jump_en(reg_jump_en), .pc_q(pc_q), .pc_plus4(pc_plus4)
    );

    function automatic logic [31:0] br_instr(logic [1:0] kind, logic [15:0] off);
        return {4'b0001, kind, 10'd0, off};
    endfunction

    function automatic logic [31:0] model_next(logic [31:0] pc, logic [31:0] ins,
            logic [31:0] a, logic [31:0] b, logic br, logic j, logic jl, logic jr);
        logic [31:0] seq;
        logic        cond;
        seq = pc + 32'd4;
        case (ins[27:26])
            2'b00: cond = (a == b);
            2'b01: cond = (a != b);
            2'b10: cond = ($signed(a) <= 0);
            default: cond = ($signed(a) > 0);
        endcase
        if (jr) return a;
        if (j || jl) return {seq[31:28], ins[25:0], 2'b00};
        if (br && cond) return seq + {{14{ins[15]}}, ins[15:0], 2'b00};
        return seq;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, logic r, logic [31:0] ins, logic [31:0] a,
            logic [31:0] b, logic br, logic j, logic jl, logic jr);
        @(negedge clk);
        rst = r; instr = ins; rs_val = a; rt_val = b;
        branch_en = br; jump_en = j; link_jump_en = jl; reg_jump_en = jr;
        if (!r) check("R2 pc_plus4", pc_plus4, model_pc + 32'd4);
        model_pc = r ? 32'd0 : model_next(model_pc, ins, a, b, br, j, jl, jr);
        exp_q.push_back(model_pc);
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) check(tag_q.pop_front(), pc_q, exp_q.pop_front());
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        drive("R1 reset", 1, '0, '0, '0, 0, 0, 0, 0);
        drive("R1 reset hold", 1, '0, '0, '0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++)
            drive("R3 sequential", 0, 32'hDEAD_BEEF, 32'd1, 32'd2, 0, 0, 0, 0);
        drive("R5 reg jump", 0, '0, 32'hA000_0100, '0, 0, 0, 0, 1);
        drive("R4 abs jump keeps region", 0, {6'b000010, 26'h0123456}, '0, '0, 0, 1, 0, 0);
        drive("R4 link jump", 0, {6'b000011, 26'h3FFFFFF}, '0, '0, 0, 0, 1, 0);
        drive("R5 priority over all", 0, br_instr(2'b00, 16'h0010), 32'h0000_0400,
              32'h0000_0400, 1, 1, 1, 1);
        drive("R6 beq taken", 0, br_instr(2'b00, 16'h0008), 32'd7, 32'd7, 1, 0, 0, 0);
        drive("R6 R10 beq not taken", 0, br_instr(2'b00, 16'h0008), 32'd7, 32'd8, 1, 0, 0, 0);
        drive("R7 R12 bne taken backward", 0, br_instr(2'b01, 16'hFFF0), 32'd1, 32'd2, 1, 0, 0, 0);
        drive("R7 bne not taken", 0, br_instr(2'b01, 16'h0020), 32'd5, 32'd5, 1, 0, 0, 0);
        drive("R8 blez negative", 0, br_instr(2'b10, 16'h0004), 32'hFFFF_FFF0, '0, 1, 0, 0, 0);
        drive("R8 blez zero", 0, br_instr(2'b10, 16'h0004), 32'd0, '0, 1, 0, 0, 0);
        drive("R8 blez positive", 0, br_instr(2'b10, 16'h0004), 32'd1, '0, 1, 0, 0, 0);
        drive("R9 bgtz positive", 0, br_instr(2'b11, 16'h0002), 32'd1, '0, 1, 0, 0, 0);
        drive("R9 bgtz zero", 0, br_instr(2'b11, 16'h0002), 32'd0, '0, 1, 0, 0, 0);
        drive("R9 bgtz min negative", 0, br_instr(2'b11, 16'h0002), 32'h8000_0000, '0, 1, 0, 0, 0);
        drive("R11 jump beats branch", 0, {4'b0001, 2'b00, 26'h0000100}, 32'd3, 32'd3, 1, 1, 0, 0);
        drive("R10 branch_en low", 0, br_instr(2'b00, 16'h0040), 32'd9, 32'd9, 0, 0, 0, 0);
        drive("R12 backward to zero", 0, br_instr(2'b00, 16'hFFFF), 32'd0, 32'd0, 1, 0, 0, 0);
        drive("R1 reset mid-run", 1, '0, 32'h1234_5678, '0, 0, 0, 0, 1);
        drive("R3 after reset", 0, '0, '0, '0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule